// File: doc/BRIEF.md
# I2C Master Command Engine

This block is a bus master for a two-wire serial bus, driven one micro-operation at a time. Software loads an 8-bit data register and then writes a 3-bit command code. The engine runs one bus step for that code: a start condition with an address byte, a byte write, a byte read with or without a leading master acknowledge, a lone acknowledge bit, or a stop condition. Every acknowledge that goes out is taken from the most significant bit of the data register. An acknowledge that comes back from the slave is placed in the least significant bit. Received bytes replace the register contents.

Both bus lines are treated as open-drain. An output-enable high pulls the line low, and the line is released for a logic 1. The data line is read back through a separate input. An 8-bit prescale value sets the length of each half of the serial clock in system clock cycles. A `busy` flag and a one-cycle `done` pulse frame each command. A command written with the abort flag set returns the engine to idle at once.

Top module: `i2c_cmd_master`

## Requirements
- R1: Codes 100 and 101 on a released bus give a start condition (data falls while clock is high), then the 8 data register bits MSB first, then one slave acknowledge slot, for 9 clock rises in total. Bit 0 of the register becomes the sampled acknowledge (0 = ACK, 1 = NAK).
- R2: Code 000 sends the 8 data register bits MSB first, then samples an acknowledge into bit 0 (0 = ACK, 1 = NAK). It uses 9 clock rises and has no start or stop.
- R3: Code 001 first drives register bit 7 as the master acknowledge (0 = ACK, 1 = NAK). It then receives 8 bits MSB first into the register, for 9 clock rises in total.
- R4: Code 010 drives register bit 7 for exactly one clock rise and leaves the register unchanged.
- R5: Code 110 receives 8 bits MSB first into the register with no leading acknowledge, in exactly 8 clock rises.
- R6: Code 111 holds data low for one clock rise and then releases data while the clock is high (a stop). Both lines are left released.
- R7: The data line changes only while the clock line is low. The two exceptions are the start phase of codes 10X and the stop phase of code 111.
- R8: `busy` rises on the cycle after an accepted command. It falls together with a one-cycle `done` pulse. Command writes and data register writes made while `busy` is high are ignored.
- R9: A command write with `cmd_abort` set clears `busy` and releases both lines on the next cycle, and starts no bus activity. Code 011 written without `cmd_abort` does nothing.
- R10: Each half of the serial clock lasts `prescale` + 2 system clock cycles.
- R11: After any command other than 111, the clock line is held low at idle. A later 10X first releases the clock with data high, which adds one clock rise for a repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | 8 | Half-period setting; each half lasts prescale+2 cycles |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 3 | Micro-operation code |
| cmd_abort | input | 1 | With cmd_we: return to idle immediately |
| data_we | input | 1 | Data register write strobe |
| data_wr | input | 8 | Value written into the data register |
| data_rd | output | 8 | Current data register contents |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| scl_oe | output | 1 | Pulls the clock line low when high |
| sda_oe | output | 1 | Pulls the data line low when high |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
A slave model watches the bus lines and counts clock rises, start and stop conditions, and the bits on the line, while a scoreboard holds the expected result of each command. The checks cover ACK and NAK on both transmit codes, so a design that stores the acknowledge inverted or puts it in the wrong bit shows a wrong register value. They also cover both receive codes, so one that adds a clock to code 110 or skips the master acknowledge of code 001 shows a wrong rise count or a shifted byte. A command and a data write made while busy are checked for no effect at all; a design that accepted them would emit a stray stop or corrupt the result. The clock high time is measured at two prescale settings, and an abort in the middle of a read is checked for an immediate release of both lines.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int SLOT_W = 4;

    localparam logic [2:0] CODE_WRITE    = 3'b000;
    localparam logic [2:0] CODE_ACK_READ = 3'b001;
    localparam logic [2:0] CODE_ACK_ONLY = 3'b010;
    localparam logic [2:0] CODE_READ     = 3'b110;
    localparam logic [2:0] CODE_STOP     = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RISE, ST_STRT, ST_LOW, ST_HIGH, ST_TAIL
    } seq_state_e;

    typedef enum logic [1:0] {
        RX_NONE, RX_SHIFT, RX_ACK
    } rx_kind_e;

    typedef struct packed {
        logic              has_start;
        logic              has_stop;
        logic [SLOT_W-1:0] slots;
        logic [8:0]        tx;     // tx[8] is driven in the current slot
    } cmd_plan_t;

    function automatic cmd_plan_t plan_cmd(input logic [2:0] code, input logic [7:0] d);
        cmd_plan_t p;
        p = '{has_start: 1'b0, has_stop: 1'b0, slots: '0, tx: 9'h1FF};
        if (code[2:1] == 2'b10) begin
            p.has_start = 1'b1;
            p.slots     = 4'd9;
            p.tx        = {d, 1'b1};
        end else begin
            case (code)
                CODE_WRITE:    begin p.slots = 4'd9; p.tx = {d, 1'b1}; end
                CODE_ACK_READ: begin p.slots = 4'd9; p.tx = {d[7], 8'hFF}; end
                CODE_ACK_ONLY: begin p.slots = 4'd1; p.tx = {d[7], 8'hFF}; end
                CODE_READ:     begin p.slots = 4'd8; p.tx = 9'h1FF; end
                CODE_STOP:     begin p.slots = 4'd1; p.tx = 9'h0FF; p.has_stop = 1'b1; end
                default:       p.slots = '0;
            endcase
        end
        return p;
    endfunction

    function automatic rx_kind_e slot_rx(input logic [2:0] code, input logic [SLOT_W-1:0] idx);
        rx_kind_e k;
        k = RX_NONE;
        if ((code[2:1] == 2'b10 || code == CODE_WRITE) && idx == 4'd8) k = RX_ACK;
        else if (code == CODE_ACK_READ && idx != 4'd0)                   k = RX_SHIFT;
        else if (code == CODE_READ)                                      k = RX_SHIFT;
        return k;
    endfunction

endpackage

// File: rtl/i2cm_halfclk.sv
module i2cm_halfclk #(
    parameter int PRESCALE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [PRESCALE_W-1:0] prescale,
    output logic                  tick
);
    localparam int CW = PRESCALE_W + 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(prescale) + CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              launch,
    input  cmd_plan_t         plan,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              done,
    output logic              smp_valid,
    output logic              smp_bit,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              scl_oe,
    output logic              sda_oe
);
    seq_state_e        state;
    logic              park_low;
    logic              stop_f;
    logic [SLOT_W-1:0] last;
    logic [8:0]        tx;
    logic              scl_want, sda_want;

    assign busy      = (state != ST_IDLE);
    assign smp_valid = (state == ST_HIGH) && tick;
    assign smp_bit   = sda_in;

    always_comb begin
        scl_want = 1'b0;
        sda_want = 1'b0;
        case (state)
            ST_IDLE: scl_want = park_low;
            ST_STRT: sda_want = 1'b1;
            ST_LOW:  begin scl_want = 1'b1; sda_want = ~tx[8]; end
            ST_HIGH: sda_want = ~tx[8];
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            park_low <= 1'b0;
            stop_f   <= 1'b0;
            last     <= '0;
            tx       <= '1;
            slot_idx <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                state    <= ST_IDLE;
                park_low <= 1'b0;
            end else begin
                case (state)
                    ST_IDLE: if (launch) begin
                        tx       <= plan.tx;
                        last     <= plan.slots - SLOT_W'(1);
                        stop_f   <= plan.has_stop;
                        slot_idx <= '0;
                        if (plan.has_start) state <= park_low ? ST_RISE : ST_STRT;
                        else                state <= ST_LOW;
                    end
                    ST_RISE: if (tick) state <= ST_STRT;
                    ST_STRT: if (tick) state <= ST_LOW;
                    ST_LOW:  if (tick) state <= ST_HIGH;
                    ST_HIGH: if (tick) begin
                        if (slot_idx == last) begin
                            if (stop_f) state <= ST_TAIL;
                            else begin
                                state    <= ST_IDLE;
                                park_low <= 1'b1;
                                done     <= 1'b1;
                            end
                        end else begin
                            slot_idx <= slot_idx + SLOT_W'(1);
                            tx       <= {tx[7:0], 1'b1};
                            state    <= ST_LOW;
                        end
                    end
                    ST_TAIL: if (tick) begin
                        state    <= ST_IDLE;
                        park_low <= 1'b0;
                        done     <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Data line updates are held back one cycle whenever the clock line moves.
    always_ff @(posedge clk) begin
        if (rst || abort) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_oe <= scl_want;
            if (scl_want == scl_oe) sda_oe <= sda_want;
        end
    end

    // R7: with the clock released on both cycles, data moves only in start or stop phase
    assert_sda_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && !$stable(sda_oe)) |->
            ($past(state) == ST_STRT || $past(state) == ST_TAIL || $past(abort)));

    // R10: a half never ends while idle
    assert_tick_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
        tick |-> busy);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int PRESCALE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRESCALE_W-1:0] prescale,
    input  logic                  cmd_we,
    input  logic [2:0]            cmd_code,
    input  logic                  cmd_abort,
    input  logic                  data_we,
    input  logic [7:0]            data_wr,
    output logic [7:0]            data_rd,
    output logic                  busy,
    output logic                  done,
    output logic                  scl_oe,
    output logic                  sda_oe,
    input  logic                  sda_in
);
    logic [7:0]        data_q;
    logic [2:0]        cur_code;
    cmd_plan_t         plan;
    logic              launch, abort, tick;
    logic              smp_valid, smp_bit;
    logic [SLOT_W-1:0] slot_idx;

    assign plan    = plan_cmd(cmd_code, data_q);
    assign abort   = cmd_we && cmd_abort;
    assign launch  = cmd_we && !cmd_abort && !busy && (plan.slots != '0);
    assign data_rd = data_q;

    i2cm_halfclk #(.PRESCALE_W(PRESCALE_W)) u_half (
        .clk(clk), .rst(rst), .run(busy), .prescale(prescale), .tick(tick)
    );

    i2cm_seq u_seq (
        .clk(clk), .rst(rst), .abort(abort), .launch(launch), .plan(plan),
        .tick(tick), .sda_in(sda_in), .busy(busy), .done(done),
        .smp_valid(smp_valid), .smp_bit(smp_bit), .slot_idx(slot_idx),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_code <= '0;
        end else if (launch) begin
            cur_code <= cmd_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (smp_valid) begin
            case (slot_rx(cur_code, slot_idx))
                RX_SHIFT: data_q    <= {data_q[6:0], smp_bit};
                RX_ACK:   data_q[0] <= smp_bit;
                default:  ;
            endcase
        end else if (data_we && !busy) begin
            data_q <= data_wr;
        end
    end

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_busy_needs_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_we));

    assert_idle_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(data_we)) |-> $stable(data_q));

    assert_abort_idles_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_abort) |=> (!busy && !scl_oe && !sda_oe));
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb_top;

    typedef struct {
        string      req;
        int         rises;
        int         starts;
        int         stops;
        logic [8:0] bits;
        logic [7:0] data;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] prescale = 8'd2;
    logic       cmd_we = 1'b0, cmd_abort = 1'b0, data_we = 1'b0;
    logic [2:0] cmd_code = 3'b000;
    logic [7:0] data_wr = 8'h00;
    logic [7:0] data_rd;
    logic       busy, done, scl_oe, sda_oe;
    logic       slave_pull = 1'b0;
    logic [8:0] mask = '0;
    logic       scl_line, sda_line;

    int         rises = 0, starts = 0, stops = 0, hi_cnt = 0;
    logic [8:0] cap = '0;
    int         n_chk = 0, n_bad = 0;
    exp_t       q[$];

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slave_pull);

    always #4 clk = ~clk;

    i2c_cmd_master dut_i (
        .clk(clk), .rst(rst), .prescale(prescale), .cmd_we(cmd_we),
        .cmd_code(cmd_code), .cmd_abort(cmd_abort), .data_we(data_we),
        .data_wr(data_wr), .data_rd(data_rd), .busy(busy), .done(done),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    // bus observer and slave
    always @(posedge scl_line) begin cap = {cap[7:0], sda_line}; rises++; end
    always @(negedge scl_line) slave_pull = (rises < 9) ? mask[rises] : 1'b0;
    always @(negedge sda_line) if (scl_line) starts++;
    always @(posedge sda_line) if (scl_line) stops++;
    always @(negedge clk) if (scl_line) hi_cnt++;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                logic [8:0] m;
                e = q.pop_front();
                m = 9'((1 << e.rises) - 1);
                check(rises == e.rises, e.req, "clock rises", rises, e.rises);
                check(starts == e.starts, e.req, "start count", starts, e.starts);
                check(stops == e.stops, e.req, "stop count", stops, e.stops);
                check((cap & m) == (e.bits & m), e.req, "bus bits", int'(cap & m), int'(e.bits & m));
                check(data_rd == e.data, e.req, "data register", data_rd, e.data);
            end
        end
    end

    function automatic logic [8:0] rd_mask(input logic [7:0] b, input int first);
        logic [8:0] m;
        m = '0;
        for (int i = 0; i < 8; i++) m[first + i] = ~b[7 - i];
        return m;
    endfunction

    task automatic issue(input logic [2:0] code, input logic [7:0] d, input logic [8:0] m);
        @(negedge clk);
        data_we = 1'b1; data_wr = d;
        @(negedge clk);
        data_we = 1'b0;
        mask = m; slave_pull = m[0];
        rises = 0; starts = 0; stops = 0; cap = '0; hi_cnt = 0;
        cmd_we = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [2:0] code, input logic [7:0] d, input logic [8:0] m, input exp_t e);
        q.push_back(e);
        issue(code, d, m);
        wait_idle();
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(busy == 1'b0, "R8", "reset busy", busy, 0);
        check(scl_line == 1'b1 && sda_line == 1'b1, "R6", "reset lines released", {scl_line, sda_line}, 3);
        check(data_rd == 8'h00, "R8", "reset data", data_rd, 0);

        // R1: start + address 0xA4, slave ACK
        run_cmd(3'b100, 8'hA4, 9'h100, '{"R1", 9, 1, 0, {8'hA4, 1'b0}, 8'hA4});
        // R2: write 0x5A, ACK
        run_cmd(3'b000, 8'h5A, 9'h100, '{"R2", 9, 0, 0, {8'h5A, 1'b0}, 8'h5A});

        // R2 with NAK, plus R8: command and data written while busy are ignored
        q.push_back('{"R2", 9, 0, 0, {8'hC2, 1'b1}, 8'hC3});
        issue(3'b000, 8'hC2, 9'h000);
        repeat (3) @(negedge clk);
        data_we = 1'b1; data_wr = 8'hFF; cmd_we = 1'b1; cmd_code = 3'b111;
        @(negedge clk);
        data_we = 1'b0; cmd_we = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R8", "command while busy stays ignored", busy, 0);
        check(stops == 0 && scl_line == 1'b0, "R8", "no stray stop", stops, 0);
        check(data_rd == 8'hC3, "R8", "data write while busy ignored", data_rd, 8'hC3);

        // R5: read first byte 0x96
        run_cmd(3'b110, 8'h00, rd_mask(8'h96, 0), '{"R5", 8, 0, 0, {1'b0, 8'h96}, 8'h96});
        // R3: master ACK then read 0x3C
        run_cmd(3'b001, 8'h00, rd_mask(8'h3C, 1), '{"R3", 9, 0, 0, {1'b0, 8'h3C}, 8'h3C});

        // R4: lone NAK, R10 high time at prescale 2
        run_cmd(3'b010, 8'h80, 9'h000, '{"R4", 1, 0, 0, 9'h001, 8'h80});
        check(hi_cnt == 4, "R10", "clock high cycles at prescale 2", hi_cnt, 4);
        prescale = 8'd5;
        run_cmd(3'b010, 8'h00, 9'h000, '{"R4", 1, 0, 0, 9'h000, 8'h00});
        check(hi_cnt == 7, "R10", "clock high cycles at prescale 5", hi_cnt, 7);
        prescale = 8'd2;

        // R11: repeated start from a parked-low clock adds one rise
        run_cmd(3'b101, 8'h50, 9'h000, '{"R11", 10, 1, 0, {8'h50, 1'b1}, 8'h51});

        // R6: stop
        run_cmd(3'b111, 8'h51, 9'h000, '{"R6", 1, 0, 1, 9'h000, 8'h51});
        check(scl_line == 1'b1 && sda_line == 1'b1, "R6", "lines released after stop", {scl_line, sda_line}, 3);

        // R1: fresh start with NAK
        run_cmd(3'b101, 8'h3A, 9'h000, '{"R1", 9, 1, 0, {8'h3A, 1'b1}, 8'h3B});

        // R9: abort in the middle of a read
        issue(3'b110, 8'h00, 9'h000);
        repeat (10) @(negedge clk);
        cmd_we = 1'b1; cmd_abort = 1'b1; cmd_code = 3'b011;
        @(negedge clk);
        cmd_we = 1'b0; cmd_abort = 1'b0;
        check(busy == 1'b0, "R9", "busy after abort", busy, 0);
        check(scl_line == 1'b1 && sda_line == 1'b1, "R9", "lines after abort", {scl_line, sda_line}, 3);

        // R9: null code without abort does nothing
        issue(3'b011, 8'h00, 9'h000);
        repeat (10) @(negedge clk);
        check(busy == 1'b0 && rises == 0, "R9", "null code activity", rises, 0);

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R8", "pending expected items", q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule